// File: doc/BRIEF.md
# IDE PIO Cycle Timing Generator

This block produces the three timed phases of a programmed-I/O transfer on an IDE-style disk interface: address setup, the strobe-active window and recovery. Up to four drives on two channels are served. Each drive's timing is held in small packed registers that the block stores itself. When a request arrives the block decodes those fields into clock counts and plays out one read or write cycle.

The first channel gives each of its two drives its own pair of timing registers. The two drives of the second channel share a single pair. A separate register times accesses to the drive command block. The setup field uses a 2-bit code that does not count in order. A count nibble of zero stands for sixteen clocks. On later silicon revisions recovery runs one clock longer, and a revision input selects that behaviour.

A host sets up the registers through a simple byte write port and can read any of them back. It then pulses `req` with the drive index, the direction and the command-block flag. It waits for `done`.

Top module: `ide_pio_timer`

## Requirements
- R1: After reset all outputs are low, the block is idle, and every timing register reads back 0.
- R2: Setup lasts a number of clocks set by bits [7:6] of the drive's address timing register: 2'b00 gives 4, 2'b10 gives 3, 2'b01 gives 2 and 2'b11 gives 5. During setup, busy is high and both strobes are low.
- R3: The strobe-active phase lasts the number of clocks in the upper nibble (bits [7:4]) of the drive's active/recovery register. A nibble of 0 gives 16 clocks, and a nibble of 1 gives 2 clocks.
- R4: Recovery lasts the number of clocks in the lower nibble (bits [3:0]) of that register, and a nibble of 0 gives 16. When the decoded active count is above 3 and the recovery nibble is 1, recovery lasts 2 clocks.
- R5: When `siliconRev` is greater than 1, recovery lasts one clock more than the count from R4. For values 0 and 1 it does not.
- R6: Drives 0 and 1 use their own register pairs: select 0/1 for drive 0 and select 2/3 for drive 1, where the even select is the address timing register and the odd select is the active/recovery register. Drives 2 and 3 both use the shared pair at select 4/5.
- R7: With `cmdBlock` high, setup is fixed at 5 clocks. Active and recovery come from the command timing register (select 6), decoded as in R3 to R5. A value of 0 therefore gives the slowest cycle.
- R8: During the active phase, `isWrite`=1 asserts only `wrStrobe` and `isWrite`=0 asserts only `rdStrobe`. The two strobes are never high together.
- R9: `busy` is high from the clock after an accepted request through the last recovery clock. `done` is high for exactly that last clock, and the block is idle on the following clock.
- R10: A request made while busy is ignored. The running cycle keeps its timing and no second cycle follows.
- R11: Bits [5:0] of an address timing register read back as written and have no effect on cycle timing.
- R12: The timing of a cycle is fixed when the request is accepted. A register write during the cycle changes only later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Write strobe for the timing registers |
| regSel | input | 3 | Register select (0..6), see R6 and R7 |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Read-back of the selected register |
| siliconRev | input | 2 | Silicon revision; values above 1 lengthen recovery |
| req | input | 1 | Start a cycle (taken only while idle) |
| isWrite | input | 1 | 1 for a write cycle, 0 for a read cycle |
| driveIdx | input | 2 | Target drive 0..3 |
| cmdBlock | input | 1 | Cycle targets the command register block |
| rdStrobe | output | 1 | Read strobe, high during the active phase of a read |
| wrStrobe | output | 1 | Write strobe, high during the active phase of a write |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | Last recovery clock of the cycle |

## Verification
Two corners are hardest to reach from the ports. The first is the recovery stretch, which needs an active nibble above 3 together with a recovery nibble of exactly 1. The second is a register rewrite that lands after a cycle has already latched its timing. The stimulus hits the first case with directed nibble pairs on both sides of the active threshold, on both revisions. For the second, the bench writes the active drive's register on the first setup clock and then re-runs the drive to show that the new value takes effect. The random part spreads drive index, setup code, nibbles, revision and direction over many cycles, and the bench counts each phase from the strobe and busy outputs.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_RECOV  = 2'd3
  } phase_e;

  // strobes from control to datapath, at most one per clock
  typedef struct packed {
    logic start;       // latch timing of the requested drive, load setup count
    logic loadActive;  // load the active-phase count
    logic loadRecov;   // load the recovery count
    logic countDown;   // decrement the phase counter
  } ctl_t;

endpackage

// File: rtl/ide_pio_dp.sv
module ide_pio_dp
  import ide_pio_pkg::*;
#(
  parameter int NIB_W     = 4,
  parameter int CMD_SETUP = 5,
  parameter int SEL_W     = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [SEL_W-1:0]     regSel,
  input  logic [2*NIB_W-1:0]   regWrData,
  output logic [2*NIB_W-1:0]   regRdData,
  input  logic [1:0]           siliconRev,
  input  logic [1:0]           driveIdx,
  input  logic                 cmdBlock,
  input  ctl_t                 ctl,
  output logic                 cntLast
);

  localparam int REG_W     = 2 * NIB_W;
  localparam int MAX_NIB   = 1 << NIB_W;
  localparam int CNT_W     = $clog2(MAX_NIB + 2);
  localparam int NUM_SLOTS = 3;
  localparam int CMD_SEL   = 2 * NUM_SLOTS;

  logic [REG_W-1:0] addrTim [NUM_SLOTS];
  logic [REG_W-1:0] drwTim  [NUM_SLOTS];
  logic [REG_W-1:0] cmdTim;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        addrTim[i] <= '0;
        drwTim[i]  <= '0;
      end
      cmdTim <= '0;
    end else if (regWrEn) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (regSel == SEL_W'(2 * i))     addrTim[i] <= regWrData;
        if (regSel == SEL_W'(2 * i + 1)) drwTim[i]  <= regWrData;
      end
      if (regSel == SEL_W'(CMD_SEL)) cmdTim <= regWrData;
    end
  end

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (regSel == SEL_W'(2 * i))     regRdData = addrTim[i];
      if (regSel == SEL_W'(2 * i + 1)) regRdData = drwTim[i];
    end
    if (regSel == SEL_W'(CMD_SEL)) regRdData = cmdTim;
  end

  function automatic logic [CNT_W-1:0] nibToClk(input logic [NIB_W-1:0] n);
    return (n == '0) ? CNT_W'(MAX_NIB) : CNT_W'(n);
  endfunction

  function automatic logic [CNT_W-1:0] setupToClk(input logic [1:0] code);
    case (code)
      2'b00:   return CNT_W'(4);
      2'b10:   return CNT_W'(3);
      2'b01:   return CNT_W'(2);
      default: return CNT_W'(5);
    endcase
  endfunction

  // second channel drives share slot 2
  logic [REG_W-1:0] addrSel, drwSrc;
  logic [NIB_W-1:0] actNib, recNib;
  logic [CNT_W-1:0] setupClk, actClk, recClk;

  always_comb begin
    addrSel  = driveIdx[1] ? addrTim[2] : (driveIdx[0] ? addrTim[1] : addrTim[0]);
    drwSrc   = cmdBlock ? cmdTim :
               (driveIdx[1] ? drwTim[2] : (driveIdx[0] ? drwTim[1] : drwTim[0]));
    setupClk = cmdBlock ? CNT_W'(CMD_SETUP) : setupToClk(addrSel[REG_W-1 -: 2]);
    actNib   = drwSrc[REG_W-1 -: NIB_W];
    recNib   = drwSrc[NIB_W-1:0];
    actClk   = nibToClk(actNib);
    if (actClk == CNT_W'(1)) actClk = CNT_W'(2);
    recClk   = nibToClk(recNib);
    if (actClk > CNT_W'(3) && recNib == NIB_W'(1)) recClk = CNT_W'(2);
    if (siliconRev > 2'd1) recClk = recClk + CNT_W'(1);
  end

  logic [CNT_W-1:0] actQ, recQ, cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actQ <= '0;
      recQ <= '0;
      cnt  <= '0;
    end else begin
      if (ctl.start) begin
        actQ <= actClk;
        recQ <= recClk;
        cnt  <= setupClk;
      end else if (ctl.loadActive) begin
        cnt  <= actQ;
      end else if (ctl.loadRecov) begin
        cnt  <= recQ;
      end else if (ctl.countDown) begin
        cnt  <= cnt - CNT_W'(1);
      end
    end
  end

  assign cntLast = (cnt == CNT_W'(1));

  // R2
  setup_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.start |=> (cnt >= CNT_W'(2)));

  // R9
  count_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.countDown |-> (cnt >= CNT_W'(2)));

  // R3
  active_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadActive |=> (cnt >= CNT_W'(2)));

endmodule

// File: rtl/ide_pio_ctrl.sv
module ide_pio_ctrl
  import ide_pio_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic req,
  input  logic isWrite,
  input  logic cntLast,
  output ctl_t ctl,
  output logic rdStrobe,
  output logic wrStrobe,
  output logic busy,
  output logic done
);

  phase_e phase, phaseNext;
  logic   writeQ;

  always_comb begin
    phaseNext = phase;
    ctl       = '0;
    case (phase)
      PH_IDLE: if (req) begin
        ctl.start = 1'b1;
        phaseNext = PH_SETUP;
      end
      PH_SETUP: if (cntLast) begin
        ctl.loadActive = 1'b1;
        phaseNext      = PH_ACTIVE;
      end else ctl.countDown = 1'b1;
      PH_ACTIVE: if (cntLast) begin
        ctl.loadRecov = 1'b1;
        phaseNext     = PH_RECOV;
      end else ctl.countDown = 1'b1;
      default: if (cntLast) phaseNext = PH_IDLE;
               else ctl.countDown = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      writeQ <= 1'b0;
    end else begin
      phase <= phaseNext;
      if (ctl.start) writeQ <= isWrite;
    end
  end

  assign busy     = (phase != PH_IDLE);
  assign done     = (phase == PH_RECOV) && cntLast;
  assign rdStrobe = (phase == PH_ACTIVE) && !writeQ;
  assign wrStrobe = (phase == PH_ACTIVE) && writeQ;

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStrobe && wrStrobe));

  // R9
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  // R3
  active_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdStrobe || wrStrobe) |-> $past(rdStrobe || wrStrobe, 2));

  // R8
  dir_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && busy) |=> !rdStrobe);

  // R9
  ctl_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctl));

endmodule

// File: rtl/ide_pio_timer.sv
module ide_pio_timer
  import ide_pio_pkg::*;
#(
  parameter int NIB_W     = 4,
  parameter int CMD_SETUP = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [2:0]           regSel,
  input  logic [2*NIB_W-1:0]   regWrData,
  output logic [2*NIB_W-1:0]   regRdData,
  input  logic [1:0]           siliconRev,
  input  logic                 req,
  input  logic                 isWrite,
  input  logic [1:0]           driveIdx,
  input  logic                 cmdBlock,
  output logic                 rdStrobe,
  output logic                 wrStrobe,
  output logic                 busy,
  output logic                 done
);

  ctl_t ctl;
  logic cntLast;

  ide_pio_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .req      (req),
    .isWrite  (isWrite),
    .cntLast  (cntLast),
    .ctl      (ctl),
    .rdStrobe (rdStrobe),
    .wrStrobe (wrStrobe),
    .busy     (busy),
    .done     (done)
  );

  ide_pio_dp #(
    .NIB_W     (NIB_W),
    .CMD_SETUP (CMD_SETUP),
    .SEL_W     (3)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regSel     (regSel),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .siliconRev (siliconRev),
    .driveIdx   (driveIdx),
    .cmdBlock   (cmdBlock),
    .ctl        (ctl),
    .cntLast    (cntLast)
  );

endmodule

// File: tb/tb_ide_pio_timer.sv
module tb_ide_pio_timer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [2:0] regSel = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [1:0] siliconRev = 2'd1;
  logic       req = 1'b0;
  logic       isWrite = 1'b0;
  logic [1:0] driveIdx = '0;
  logic       cmdBlock = 1'b0;
  logic       rdStrobe, wrStrobe, busy, done;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [7:0] shAddr [3];
  logic [7:0] shDrw  [3];
  logic [7:0] shCmd;

  always #10 clk = ~clk;

  ide_pio_timer dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .siliconRev(siliconRev),
    .req(req), .isWrite(isWrite), .driveIdx(driveIdx), .cmdBlock(cmdBlock),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, cycles %0d expected below 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expSetup(input logic [1:0] code);
    case (code)
      2'b00: return 4;
      2'b10: return 3;
      2'b01: return 2;
      default: return 5;
    endcase
  endfunction

  function automatic int expAct(input logic [7:0] b);
    int a = (b[7:4] == 0) ? 16 : int'(b[7:4]);
    return (a == 1) ? 2 : a;
  endfunction

  function automatic int expRec(input logic [7:0] b, input logic [1:0] rev);
    int r = (b[3:0] == 0) ? 16 : int'(b[3:0]);
    if (expAct(b) > 3 && b[3:0] == 4'd1) r = 2;
    if (rev > 2'd1) r = r + 1;
    return r;
  endfunction

  function automatic int slotOf(input logic [1:0] d);
    return d[1] ? 2 : int'(d[0]);
  endfunction

  task automatic wrReg(input logic [2:0] sel, input logic [7:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
    if (sel == 3'd6) shCmd = val;
    else if (sel[0]) shDrw[sel[2:1]] = val;
    else shAddr[sel[2:1]] = val;
  endtask

  task automatic rdChk(input logic [2:0] sel, input logic [7:0] exp, input string tag);
    @(negedge clk);
    regSel = sel;
    #1;
    check(regRdData == exp, tag, int'(regRdData), int'(exp));
  endtask

  // inject: 0 none, 1 req pulse during setup, 2 register write during setup
  task automatic runCyc(input logic [1:0] drv, input bit cmd, input bit wr,
                        input int eS, input int eA, input int eR, input int inject,
                        input logic [2:0] injSel, input logic [7:0] injVal,
                        input string tag);
    int s = 0, a = 0, r = 0, bad = 0, dn = 0;
    bit lastDn = 0;
    @(negedge clk);
    req = 1'b1; isWrite = wr; driveIdx = drv; cmdBlock = cmd;
    @(negedge clk);
    req = 1'b0;
    if (inject == 1) req = 1'b1;
    if (inject == 2) begin regWrEn = 1'b1; regSel = injSel; regWrData = injVal; end
    while (busy && !rdStrobe && !wrStrobe) begin
      s++;
      @(negedge clk); req = 1'b0; regWrEn = 1'b0;
    end
    while (rdStrobe || wrStrobe) begin
      if (wr ? (rdStrobe || !wrStrobe) : (wrStrobe || !rdStrobe)) bad++;
      a++;
      @(negedge clk); req = 1'b0; regWrEn = 1'b0;
    end
    while (busy) begin
      r++;
      if (done) dn++;
      lastDn = done;
      @(negedge clk); req = 1'b0; regWrEn = 1'b0;
    end
    check(s == eS, {tag, " setup clocks"}, s, eS);
    check(a == eA, {tag, " active clocks"}, a, eA);
    check(r == eR, {tag, " recovery clocks"}, r, eR);
    check(bad == 0, {tag, " R8 strobe direction"}, bad, 0);
    check(dn == 1 && lastDn, {tag, " R9 single done on last clock"}, dn, 1);
  endtask

  task automatic runDrv(input logic [1:0] drv, input bit wr, input string tag);
    int sl = slotOf(drv);
    runCyc(drv, 1'b0, wr, expSetup(shAddr[sl][7:6]), expAct(shDrw[sl]),
           expRec(shDrw[sl], siliconRev), 0, 3'd0, 8'd0, tag);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin shAddr[i] = '0; shDrw[i] = '0; end
    shCmd = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !rdStrobe && !wrStrobe, "R1 outputs idle in reset", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !rdStrobe && !wrStrobe, "R1 outputs idle after reset", int'(busy), 0);
    for (int i = 0; i < 7; i++) rdChk(3'(i), 8'h00, "R1 register reset value");

    // R2 every setup code, drive 0
    for (int c = 0; c < 4; c++) begin
      wrReg(3'd0, {2'(c), 6'd0});
      wrReg(3'd1, 8'h22);
      runDrv(2'd0, 1'b0, "R2 setup code");
    end

    // R3 active nibble 0 and 1, R4 recovery nibble 0
    wrReg(3'd1, 8'h00); runDrv(2'd0, 1'b1, "R3 R4 zero nibbles are 16");
    wrReg(3'd1, 8'h13); runDrv(2'd0, 1'b0, "R3 active 1 acts as 2");
    // R4 recovery stretch on both sides of the active threshold
    wrReg(3'd1, 8'h41); runDrv(2'd0, 1'b0, "R4 active 4 recovery 1 gives 2");
    wrReg(3'd1, 8'h31); runDrv(2'd0, 1'b1, "R4 active 3 recovery 1 stays 1");
    // R5 revision adds a recovery clock
    siliconRev = 2'd2;
    wrReg(3'd1, 8'h31); runDrv(2'd0, 1'b0, "R5 rev 2 recovery plus one");
    wrReg(3'd1, 8'h41); runDrv(2'd0, 1'b0, "R5 rev 2 with stretch");
    siliconRev = 2'd0;
    runDrv(2'd0, 1'b0, "R5 rev 0 no extra clock");
    siliconRev = 2'd1;

    // R6 drive mapping
    wrReg(3'd0, 8'h40); wrReg(3'd1, 8'h23);
    wrReg(3'd2, 8'hC0); wrReg(3'd3, 8'h75);
    wrReg(3'd4, 8'h80); wrReg(3'd5, 8'h39);
    runDrv(2'd0, 1'b0, "R6 drive 0 own pair");
    runDrv(2'd1, 1'b1, "R6 drive 1 own pair");
    runCyc(2'd2, 1'b0, 1'b0, 3, 3, 9, 0, 3'd0, 8'd0, "R6 drive 2 shared pair");
    runCyc(2'd3, 1'b0, 1'b1, 3, 3, 9, 0, 3'd0, 8'd0, "R6 drive 3 shared pair");

    // R7 command block timing
    runCyc(2'd0, 1'b1, 1'b0, 5, 16, 16, 0, 3'd0, 8'd0, "R7 command reg 0 slowest");
    wrReg(3'd6, 8'h35);
    runCyc(2'd3, 1'b1, 1'b1, 5, 3, 5, 0, 3'd0, 8'd0, "R7 command reg programmed");
    rdChk(3'd6, 8'h35, "R7 command register readback");

    // R10 req while busy ignored
    runCyc(2'd1, 1'b0, 1'b0, 5, 7, 5, 1, 3'd0, 8'd0, "R10 request during cycle");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!busy, "R10 no second cycle", int'(busy), 0);
    end

    // R11 low six bits stored, no timing effect
    wrReg(3'd0, 8'hAA);
    rdChk(3'd0, 8'hAA, "R11 low bits readback");
    wrReg(3'd1, 8'h23);
    runCyc(2'd0, 1'b0, 1'b0, 3, 2, 3, 0, 3'd0, 8'd0, "R11 low bits no effect");
    wrReg(3'd0, 8'h3F);
    rdChk(3'd0, 8'h3F, "R11 low bits readback all ones");
    runCyc(2'd0, 1'b0, 1'b1, 4, 2, 3, 0, 3'd0, 8'd0, "R11 all ones low bits");

    // R12 write during cycle affects only the next cycle
    runCyc(2'd0, 1'b0, 1'b0, 4, 2, 3, 2, 3'd1, 8'h96, "R12 mid-cycle write");
    shDrw[0] = 8'h96;
    runCyc(2'd0, 1'b0, 1'b0, 4, 9, 6, 0, 3'd0, 8'd0, "R12 next cycle new timing");

    // constrained random mix (R2 R3 R4 R5 R6 R8)
    for (int n = 0; n < 40; n++) begin
      logic [1:0] drv = 2'($urandom_range(0, 3));
      logic [7:0] av  = 8'($urandom);
      logic [7:0] dv  = 8'($urandom);
      bit cmd = ($urandom_range(0, 5) == 0);
      bit wr  = 1'($urandom);
      int sl  = slotOf(drv);
      siliconRev = 2'($urandom);
      if (n % 4 == 0) dv[3:0] = 4'd1;
      if (cmd) begin
        wrReg(3'd6, dv);
        runCyc(drv, 1'b1, wr, 5, expAct(dv), expRec(dv, siliconRev), 0, 3'd0, 8'd0,
               "R7 random command cycle");
      end else begin
        wrReg(3'(2 * sl), av);
        wrReg(3'(2 * sl + 1), dv);
        runDrv(drv, wr, "R2 R3 R4 R5 R6 random cycle");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule